// File: doc/BRIEF.md
# Down-Counting PWM Timer with Window Mode

This block is one timer channel that turns a free-running down-counter into a pulse-width-modulated output. A period register sets the value the counter reloads after it reaches zero. One period therefore lasts period + 1 clocks. A mode code in the control register decides how the count becomes an output level. In single-threshold mode the pin is high while the count lies above an upper threshold. In window mode the pin is high only while the count lies strictly between a lower and an upper threshold.

Software drives the block through a plain write port that has five addresses. Writing the counter directly restarts the waveform at a chosen phase, so a new period can take effect at once. The output pin is registered and trails the counter by one clock.

Top module: `tpwm_top`

## Requirements
- R1: After a synchronous active-high reset, every register and the counter are zero and `pwm_o` is 0.
- R2: A write with `wr_en` high lands at that clock edge. Address 0 is control, where bit 0 is the enable and bits [6:4] are the mode code. Address 1 is the period, address 2 is the counter, address 3 is the upper threshold and address 4 is the lower threshold. Any other address is ignored.
- R3: While the block is enabled and the period is nonzero, the counter decrements by one per clock. On the clock after it holds 0, it reloads the period, so one period spans period + 1 clocks.
- R4: A write to address 2 loads the counter with `wr_data` on that edge. This write overrides counting, disable and a zero period.
- R5: Mode code 3 (single threshold) drives `pwm_o` high in the clock after a cycle in which the count is strictly greater than the upper threshold.
- R6: Mode code 4 (window) drives `pwm_o` high in the clock after a cycle in which lower threshold < count < upper threshold.
- R7: In window mode, if the lower threshold is greater than or equal to the upper threshold, `pwm_o` stays 0.
- R8: While enable is 0, `pwm_o` is 0 and the counter keeps its value. After re-enabling, the waveform resumes from the held count.
- R9: A period of 0 forces `pwm_o` to 0 and freezes the counter. Writing a nonzero period resumes counting from the held value.
- R10: Any mode code other than 3 or 4 drives `pwm_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R2) |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output pin |

## Verification
A write lands at the edge on which it is sampled. The first output level that depends on it is computed from the count present after that edge, so it appears one edge later, two edges after the write strobe is driven. Each directed task therefore ends its last write and then begins sampling at the next falling edge. From there it keeps its own count, which steps down and wraps once per clock, or stays put while the block is disabled or the period is zero. Each sample is compared with the level that the requirements give for that count. This one-clock lag is applied in the same way to restarts, re-enables after a hold, and a period that becomes nonzero.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    localparam int ADDR_W   = 3;
    localparam int MODE_W   = 3;
    localparam int EN_BIT   = 0;
    localparam int MODE_LSB = 4;

    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd3;
    localparam logic [MODE_W-1:0] MODE_WINDOW = 3'd4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_PERIOD = 3'd1,
        REG_COUNT  = 3'd2,
        REG_CMP_HI = 3'd3,
        REG_CMP_LO = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    // Output level for one count value; widths are zero-extended by the caller.
    function automatic logic pwm_level(input logic [MODE_W-1:0] mode,
                                       input logic [31:0] cnt,
                                       input logic [31:0] hi,
                                       input logic [31:0] lo);
        logic lvl;
        case (mode)
            MODE_SINGLE: lvl = (cnt > hi);
            MODE_WINDOW: lvl = (cnt > lo) && (cnt < hi);
            default:     lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output ctrl_t               ctrl_q,
    output logic [CNT_W-1:0]    period_q,
    output logic [CNT_W-1:0]    cmp_hi_q,
    output logic [CNT_W-1:0]    cmp_lo_q,
    output logic                cnt_load,
    output logic [CNT_W-1:0]    cnt_load_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            cmp_hi_q <= '0;
            cmp_lo_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    ctrl_q.en   <= wr_data[EN_BIT];
                    ctrl_q.mode <= wr_data[MODE_LSB +: MODE_W];
                end
                REG_PERIOD: period_q <= wr_data;
                REG_CMP_HI: cmp_hi_q <= wr_data;
                REG_CMP_LO: cmp_lo_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_load     = wr_en && (wr_addr == REG_COUNT);
        cnt_load_val = wr_data;
    end

endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic period_ok;
    assign period_ok = (period != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && period_ok) begin
            cnt_q <= (cnt_q == '0) ? period : cnt_q - ONE;
        end
    end

endmodule

// File: rtl/tpwm_shaper.sv
module tpwm_shaper
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_hi,
    input  logic [CNT_W-1:0] cmp_lo,
    output logic             pwm_q
);

    logic lvl;

    always_comb begin
        lvl = ctrl.en && (period != '0) &&
              pwm_level(ctrl.mode, 32'(cnt), 32'(cmp_hi), 32'(cmp_lo));
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= lvl;
    end

endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output logic                  pwm_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cmp_hi_q;
    logic [CNT_W-1:0] cmp_lo_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic [CNT_W-1:0] cnt_q;

    tpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl_q       (ctrl_q),
        .period_q     (period_q),
        .cmp_hi_q     (cmp_hi_q),
        .cmp_lo_q     (cmp_lo_q),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val)
    );

    tpwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.en),
        .period   (period_q),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .cnt_q    (cnt_q)
    );

    tpwm_shaper #(.CNT_W(CNT_W)) u_shaper (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl_q),
        .period (period_q),
        .cnt    (cnt_q),
        .cmp_hi (cmp_hi_q),
        .cmp_lo (cmp_lo_q),
        .pwm_q  (pwm_o)
    );

endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cmp_hi,
    input logic [CNT_W-1:0] cmp_lo,
    input logic [CNT_W-1:0] cnt,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic             pwm
);

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (!pwm && cnt == '0));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && period != '0 && cnt == '0 && !load) |=> (cnt == $past(period)));

    // R4
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    // R5
    single_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && period != '0 && ctrl.mode == MODE_SINGLE && cnt > cmp_hi) |=> pwm);

    // R7
    empty_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_WINDOW && cmp_lo >= cmp_hi) |=> !pwm);

    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> !pwm);

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !load) |=> $stable(cnt));

    // R9
    zero_period_chk: assert property (@(posedge clk) disable iff (rst)
        (period == '0 && !load) |=> ($stable(cnt) && !pwm));

    // R10
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode != MODE_SINGLE && ctrl.mode != MODE_WINDOW) |=> !pwm);

endmodule

bind tpwm_top tpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_q),
    .period   (period_q),
    .cmp_hi   (cmp_hi_q),
    .cmp_lo   (cmp_lo_q),
    .cnt      (cnt_q),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .pwm      (pwm_o)
);

// File: tb/tpwm_top_tb.sv
module tpwm_top_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_o;

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side view of the programmed registers
    bit       m_en;
    int       m_mode, m_per, m_hi, m_lo;

    always #4 clk = ~clk;   // 125 MHz

    tpwm_top #(.CNT_W(CNT_W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    task automatic check(input bit got, input bit exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_o actual %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (addr)
            0: begin m_en = data[0]; m_mode = (data >> 4) & 7; end
            1: m_per = data;
            3: m_hi  = data;
            4: m_lo  = data;
            default: ;
        endcase
    endtask

    function automatic bit expect_lvl(input int c);
        if (!m_en || m_per == 0) return 1'b0;
        if (m_mode == 3) return c > m_hi;
        if (m_mode == 4) return (c > m_lo) && (c < m_hi);
        return 1'b0;
    endfunction

    // Samples n clocks, starting with the level for count 'start'
    task automatic run(input int start, input int n, input string req);
        int c = start;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(pwm_o, expect_lvl(c), req);
            if (m_en && m_per != 0) c = (c == 0) ? m_per : c - 1;
        end
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pwm_o, 1'b0, "R1");
        end
    endtask

    task automatic t_single();
        wr(1, 9); wr(3, 4); wr(0, 'h31); wr(2, 9);
        run(9, 20, "R5 R3 R4");
        wr(3, 0); wr(2, 9);
        run(9, 10, "R5 full");
        wr(3, 9); wr(2, 9);
        run(9, 10, "R5 none");
    endtask

    task automatic t_window();
        wr(3, 7); wr(4, 2); wr(0, 'h41); wr(2, 9);
        run(9, 20, "R6");
        wr(3, 6); wr(4, 6); wr(2, 9);
        run(9, 10, "R7 equal");
        wr(3, 3); wr(4, 8); wr(2, 9);
        run(9, 10, "R7 inverted");
    endtask

    task automatic t_disable();
        wr(3, 7); wr(4, 2); wr(0, 'h40); wr(2, 5);
        run(5, 8, "R8 low");
        wr(0, 'h41);
        run(5, 12, "R8 resume");
    endtask

    task automatic t_period();
        wr(1, 4); wr(3, 1); wr(0, 'h31); wr(2, 4);
        run(4, 10, "R3 R4 period4");
    endtask

    task automatic t_zero_period();
        wr(1, 0); wr(2, 3);
        run(3, 6, "R9 low");
        wr(3, 2); wr(1, 6);
        run(3, 10, "R9 resume");
    endtask

    task automatic t_bad_mode();
        wr(1, 9); wr(0, 'h51); wr(2, 9);
        run(9, 10, "R10 code5");
        wr(0, 'h01); wr(2, 9);
        run(9, 10, "R10 code0");
        wr(7, 'h31);
        run(9, 4, "R2 unused addr");
    endtask

    initial begin
        m_en = 0; m_mode = 0; m_per = 0; m_hi = 0; m_lo = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_window();
        t_disable();
        t_period();
        t_zero_period();
        t_bad_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule